// File: doc/BRIEF.md
# Early-Acknowledge Invalidation Queue

This block sits where coherence Invalidate messages enter a cache. Each accepted message is acknowledged on the next clock. The line is not touched at that point. The requesting core's store buffer therefore gets its acknowledgement without waiting for the tag update. The addresses are held in an in-order queue. A background sequencer later takes them out one per cycle and clears the matching line's valid state in a small direct-mapped tag store.

Because the acknowledgement runs ahead of the invalidation, a lookup can still report a hit on a line whose invalidation is only queued. This stale window is allowed. A barrier request closes it: later loads are stalled until every queued entry has been applied, and then a one-cycle barrier-done pulse releases them. A fill port marks lines present. Fills share the single tag write port with the sequencer and take priority over it. The `tag_port_busy` input lets the surrounding cache hold the sequencer off for other tag accesses.

Top module: `inval_queue`

## Requirements
- R1: `inv_ready` is low exactly while the queue holds DEPTH entries. A message offered while `inv_ready` is low is not accepted and receives no acknowledgement.
- R2: `inv_ack` is high for one cycle on the clock after each accepted message (`inv_valid` and `inv_ready` both high at a rising edge). At all other times it is low.
- R3: In the cycle in which `inv_ack` is high, the acknowledged line has not yet been invalidated, so `ld_hit` for its address can still read 1.
- R4: At most one queued entry is applied per cycle, strictly in arrival order.
- R5: Applying an entry whose address matches a present line (the valid set selected by the low log2(SETS) address bits, holding the remaining upper bits as tag) makes `ld_hit` for that address read 0 after that edge.
- R6: Applying an entry whose address is absent (the set is invalid, or it holds another tag) changes nothing: a line sharing the set index stays present.
- R7: A `bar_req` pulse makes `ld_stall` read 1 from the following cycle until `bar_done` is high.
- R8: With a barrier pending, `bar_done` is high for one cycle. That cycle follows the first edge at which the queue was seen empty. `ld_stall` is low from that cycle on.
- R9: A fill writes its line present on the next edge. In a cycle with a fill or with `tag_port_busy` high, no queued entry is applied.
- R10: After reset the queue is empty, every line is absent, `inv_ready` is 1, and `inv_ack`, `ld_stall` and `bar_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| inv_valid | input | 1 | Invalidate message offered |
| inv_addr | input | AW | Line address of the Invalidate |
| inv_ready | output | 1 | Queue can accept a message this cycle |
| inv_ack | output | 1 | Acknowledge, one cycle after acceptance |
| fill_valid | input | 1 | Mark a line present (priority on the tag port) |
| fill_addr | input | AW | Line address to fill |
| tag_port_busy | input | 1 | Tag write port taken by other logic; sequencer waits |
| bar_req | input | 1 | Full-barrier request pulse |
| bar_done | output | 1 | Barrier complete, one-cycle pulse |
| ld_addr | input | AW | Load lookup address |
| ld_hit | output | 1 | Line for `ld_addr` is present |
| ld_stall | output | 1 | Loads must wait for a pending barrier |

## Verification
The checks assume a requester that offers messages only under the valid/ready rule, with no expectation that an unaccepted message is held. They also assume that `bar_req` is treated as a pulse. The stimulus therefore drives `inv_valid` freely into a full queue and expects only the ready gating to protect the queue. It raises `bar_req` for single cycles, both with entries queued and with the queue already empty. Fills and the hold input are used on purpose to freeze the sequencer, so the stale-hit window and the full condition become observable at the ports.

// File: rtl/iq_pkg.sv
package iq_pkg;
  // Barrier sequencing: idle, waiting for drain, one-cycle release.
  typedef enum logic [1:0] {
    BAR_IDLE = 2'd0,
    BAR_WAIT = 2'd1,
    BAR_REL  = 2'd2
  } bar_state_e;

  function automatic logic bar_blocks(input bar_state_e s);
    return s == BAR_WAIT;
  endfunction

  function automatic logic bar_releases(input bar_state_e s);
    return s == BAR_REL;
  endfunction
endpackage

// File: rtl/iq_fifo.sv
module iq_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [W-1:0]  slot [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] fill_lvl;

  always_ff @(posedge clk) begin
    if (push) slot[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      fill_lvl <= '0;
    end else begin
      if (push) wr_ptr <= step_ptr(wr_ptr);
      if (pop)  rd_ptr <= step_ptr(rd_ptr);
      case ({push, pop})
        2'b10:   fill_lvl <= fill_lvl + 1'b1;
        2'b01:   fill_lvl <= fill_lvl - 1'b1;
        default: fill_lvl <= fill_lvl;
      endcase
    end
  end

  assign head  = slot[rd_ptr];
  assign count = fill_lvl;
  assign empty = (fill_lvl == '0);
endmodule

// File: rtl/iq_tag_store.sv
module iq_tag_store #(
  parameter int AW   = 16,
  parameter int SETS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fill_en,
  input  logic [AW-1:0] fill_addr,
  input  logic          clr_en,
  input  logic [AW-1:0] clr_addr,
  input  logic [AW-1:0] look_addr,
  output logic          look_hit,
  output logic          clr_match
);
  localparam int IW = $clog2(SETS);
  localparam int TW = AW - IW;

  function automatic logic [IW-1:0] set_of(input logic [AW-1:0] a);
    return a[IW-1:0];
  endfunction

  function automatic logic [TW-1:0] tag_of(input logic [AW-1:0] a);
    return a[AW-1:IW];
  endfunction

  logic          vld [SETS];
  logic [TW-1:0] tg  [SETS];

  assign clr_match = vld[set_of(clr_addr)]  && (tg[set_of(clr_addr)]  == tag_of(clr_addr));
  assign look_hit  = vld[set_of(look_addr)] && (tg[set_of(look_addr)] == tag_of(look_addr));

  for (genvar g = 0; g < SETS; g++) begin : g_set
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld[g] <= 1'b0;
        tg[g]  <= '0;
      end else if (fill_en && set_of(fill_addr) == IW'(g)) begin
        vld[g] <= 1'b1;
        tg[g]  <= tag_of(fill_addr);
      end else if (clr_en && clr_match && set_of(clr_addr) == IW'(g)) begin
        vld[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/iq_barrier_ctl.sv
module iq_barrier_ctl
  import iq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic q_empty,
  output logic stall,
  output logic done
);
  bar_state_e st, st_nx;

  always_comb begin
    st_nx = st;
    case (st)
      BAR_IDLE: if (req) st_nx = BAR_WAIT;
      BAR_WAIT: if (q_empty) st_nx = BAR_REL;
      BAR_REL:  st_nx = req ? BAR_WAIT : BAR_IDLE;
      default:  st_nx = BAR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= BAR_IDLE;
    else        st <= st_nx;
  end

  assign stall = bar_blocks(st);
  assign done  = bar_releases(st);
endmodule

// File: rtl/inval_queue.sv
module inval_queue #(
  parameter int AW    = 16,
  parameter int DEPTH = 4,
  parameter int SETS  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inv_valid,
  input  logic [AW-1:0] inv_addr,
  output logic          inv_ready,
  output logic          inv_ack,
  input  logic          fill_valid,
  input  logic [AW-1:0] fill_addr,
  input  logic          tag_port_busy,
  input  logic          bar_req,
  output logic          bar_done,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_hit,
  output logic          ld_stall
);
  localparam int CW = $clog2(DEPTH + 1);

  // Named internal events, observed by the bound checker.
  logic          inv_push;
  logic          seq_apply;
  logic [CW-1:0] q_count;
  logic          q_empty;
  logic [AW-1:0] q_head;
  logic          head_present;

  assign inv_ready = (q_count != CW'(DEPTH));
  assign inv_push  = inv_valid && inv_ready;
  assign seq_apply = !q_empty && !fill_valid && !tag_port_busy;

  iq_fifo #(.W(AW), .DEPTH(DEPTH)) fifo_i (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (inv_push),
    .din   (inv_addr),
    .pop   (seq_apply),
    .head  (q_head),
    .count (q_count),
    .empty (q_empty)
  );

  iq_tag_store #(.AW(AW), .SETS(SETS)) tags_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .fill_en   (fill_valid),
    .fill_addr (fill_addr),
    .clr_en    (seq_apply),
    .clr_addr  (q_head),
    .look_addr (ld_addr),
    .look_hit  (ld_hit),
    .clr_match (head_present)
  );

  iq_barrier_ctl bar_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (bar_req),
    .q_empty (q_empty),
    .stall   (ld_stall),
    .done    (bar_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inv_ack <= 1'b0;
    else        inv_ack <= inv_push;
  end
endmodule

// File: rtl/inval_queue_chk.sv
module inval_queue_chk #(
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          inv_ready,
  input logic          inv_ack,
  input logic          inv_push,
  input logic          seq_apply,
  input logic [CW-1:0] q_count,
  input logic          fill_valid,
  input logic          tag_port_busy,
  input logic          bar_req,
  input logic          bar_done,
  input logic          ld_stall
);
  // R1
  full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_count == CW'(DEPTH)) |-> !inv_ready);
  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CW'(DEPTH));
  // R2
  ack_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_push |=> inv_ack);
  // R2
  no_stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inv_push |=> !inv_ack);
  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_apply |-> (q_count != '0));
  // R9
  port_yield_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid || tag_port_busy) |-> !seq_apply);
  // R7
  stall_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bar_req |=> (ld_stall || bar_done));
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bar_done |=> !bar_done);
  // R8
  done_after_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bar_done |-> $past(q_count == '0));
  // R8
  done_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bar_done |-> (!ld_stall && $past(ld_stall)));
endmodule

bind inval_queue inval_queue_chk #(.DEPTH(DEPTH), .CW(CW)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .inv_ready     (inv_ready),
  .inv_ack       (inv_ack),
  .inv_push      (inv_push),
  .seq_apply     (seq_apply),
  .q_count       (q_count),
  .fill_valid    (fill_valid),
  .tag_port_busy (tag_port_busy),
  .bar_req       (bar_req),
  .bar_done      (bar_done),
  .ld_stall      (ld_stall)
);

// File: tb/inval_queue_tb_top.sv
`timescale 1ns/1ps
module inval_queue_tb_top;
  localparam int AW = 16;
  localparam logic [AW-1:0] LA = 16'h0011; // set 1, tag 2
  localparam logic [AW-1:0] LB = 16'h0022; // set 2, tag 4
  localparam logic [AW-1:0] LC = 16'h0019; // set 1, tag 3 (absent twin of LA)
  localparam logic [AW-1:0] LD = 16'h0033; // set 3, tag 6

  typedef struct packed {
    logic          iv;
    logic [AW-1:0] ia;
    logic          fv;
    logic [AW-1:0] fa;
    logic          hold;
    logic          br;
    logic [AW-1:0] la;
    logic          rdy;
    logic          ack;
    logic          hit;
    logic          stall;
    logic          done;
    logic [3:0]    rq;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 16'h0, 1'b1, LA,    1'b0, 1'b0, LA, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd9}, // R9 fill A
    '{1'b0, 16'h0, 1'b1, LB,    1'b0, 1'b0, LB, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd9}, // R9 fill B
    '{1'b0, 16'h0, 1'b1, LD,    1'b0, 1'b0, LD, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd9}, // R9 fill D
    '{1'b1, LC,    1'b0, 16'h0, 1'b1, 1'b0, LA, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd2}, // R2 queue absent C
    '{1'b1, LA,    1'b0, 16'h0, 1'b1, 1'b0, LA, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd3}, // R3 acked, A stale hit
    '{1'b1, LB,    1'b0, 16'h0, 1'b1, 1'b0, LB, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd3}, // R3
    '{1'b1, LD,    1'b0, 16'h0, 1'b1, 1'b0, LD, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd1}, // R1 now full
    '{1'b1, LA,    1'b0, 16'h0, 1'b1, 1'b0, LA, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd1}, // R1 refused, no ack
    '{1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0, LA, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd6}, // R6 C applied, A kept
    '{1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0, LA, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5}, // R5 A cleared
    '{1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0, LB, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4}, // R4 B next in order
    '{1'b0, 16'h0, 1'b0, 16'h0, 1'b1, 1'b1, LD, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'd7}, // R7 barrier, D queued
    '{1'b0, 16'h0, 1'b0, 16'h0, 1'b1, 1'b0, LD, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'd7}, // R7 still stalled
    '{1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0, LD, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd8}, // R8 D applied, not yet done
    '{1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0, LD, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd8}, // R8 done pulse
    '{1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0, LD, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8}, // R8 single pulse
    '{1'b1, LA,    1'b1, LA,    1'b0, 1'b0, LA, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd9}, // R9 fill+queue A
    '{1'b0, 16'h0, 1'b1, LB,    1'b0, 1'b0, LA, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd9}, // R9 fill blocks apply
    '{1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0, LA, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5}, // R5
    '{1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 1'b1, LB, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'd7}, // R7 barrier on empty queue
    '{1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0, LB, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'd8}, // R8
    '{1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0, LB, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd8}  // R8
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          inv_valid = 1'b0;
  logic [AW-1:0] inv_addr = '0;
  logic          inv_ready, inv_ack;
  logic          fill_valid = 1'b0;
  logic [AW-1:0] fill_addr = '0;
  logic          tag_port_busy = 1'b0;
  logic          bar_req = 1'b0;
  logic          bar_done;
  logic [AW-1:0] ld_addr = '0;
  logic          ld_hit, ld_stall;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  inval_queue #(.AW(AW), .DEPTH(4), .SETS(8)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .inv_valid(inv_valid), .inv_addr(inv_addr), .inv_ready(inv_ready), .inv_ack(inv_ack),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .tag_port_busy(tag_port_busy),
    .bar_req(bar_req), .bar_done(bar_done),
    .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_stall(ld_stall)
  );

  task automatic chk(input string what, input int rq, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %b expected %b at %0t", rq, what, act, exp, $time);
    end
  endtask

  // Drive at the falling edge, sample 1 ns after the next rising edge.
  task automatic cyc(input logic iv, input logic [AW-1:0] ia, input logic fv,
                     input logic [AW-1:0] fa, input logic hold, input logic br,
                     input logic [AW-1:0] la);
    @(negedge clk);
    inv_valid = iv; inv_addr = ia; fill_valid = fv; fill_addr = fa;
    tag_port_busy = hold; bar_req = br; ld_addr = la;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    ld_addr = LA;
    #1;
    // R10 reset state
    chk("reset ready", 10, inv_ready, 1'b1);
    chk("reset ack",   10, inv_ack,   1'b0);
    chk("reset stall", 10, ld_stall,  1'b0);
    chk("reset done",  10, bar_done,  1'b0);
    chk("reset hit",   10, ld_hit,    1'b0);

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i].iv, VEC[i].ia, VEC[i].fv, VEC[i].fa, VEC[i].hold, VEC[i].br, VEC[i].la);
      chk($sformatf("row %0d ready", i), int'(VEC[i].rq), inv_ready, VEC[i].rdy);
      chk($sformatf("row %0d ack",   i), int'(VEC[i].rq), inv_ack,   VEC[i].ack);
      chk($sformatf("row %0d hit",   i), int'(VEC[i].rq), ld_hit,    VEC[i].hit);
      chk($sformatf("row %0d stall", i), int'(VEC[i].rq), ld_stall,  VEC[i].stall);
      chk($sformatf("row %0d done",  i), int'(VEC[i].rq), bar_done,  VEC[i].done);
    end

    // R4 arrival order: refill A and D, queue A then D under hold, release.
    cyc(1'b0, '0, 1'b1, LA, 1'b0, 1'b0, LA);
    cyc(1'b0, '0, 1'b1, LD, 1'b0, 1'b0, LD);
    cyc(1'b1, LA, 1'b0, '0, 1'b1, 1'b0, LD);
    cyc(1'b1, LD, 1'b0, '0, 1'b1, 1'b0, LD);
    chk("D present while held", 4, ld_hit, 1'b1);
    cyc(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, LD);
    chk("D survives first apply", 4, ld_hit, 1'b1);
    cyc(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, LA);
    chk("A already cleared", 4, ld_hit, 1'b0);
    ld_addr = LD; #0.5;
    chk("D cleared second", 4, ld_hit, 1'b0);

    // R2 back-to-back acceptance with the sequencer running.
    cyc(1'b1, LB, 1'b0, '0, 1'b0, 1'b0, LB);
    chk("stream ack 1", 2, inv_ack, 1'b1);
    cyc(1'b1, LC, 1'b0, '0, 1'b0, 1'b0, LB);
    chk("stream ack 2", 2, inv_ack, 1'b1);
    cyc(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, LB);
    chk("stream ack ends", 2, inv_ack, 1'b0);
    chk("stream ready", 1, inv_ready, 1'b1);
    cyc(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, LB);

    // R10 reset mid-run clears present lines.
    cyc(1'b0, '0, 1'b1, LB, 1'b0, 1'b0, LB);
    chk("B present before reset", 9, ld_hit, 1'b1);
    @(negedge clk);
    fill_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("reset clears line", 10, ld_hit, 1'b0);
    chk("reset ready again", 10, inv_ready, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule